// File: doc/BRIEF.md
# Three-Channel Watchdog Timer

This block holds three independent watchdog channels behind a small byte-addressed register bus. Each channel has a 16-bit downcounter, a reload limit and a status byte. The counter ticks once per tenth of a second, and a shared prescaler divides the input clock down to that rate. Software starts a channel by writing its limit. It keeps the channel alive by reading the live counter, which returns the current count and restarts the countdown from the limit.

When a counter reaches zero, its channel expires and takes its own action. Channel 0 raises a level interrupt. Channel 1 drives a fixed-length CPU reset pulse. Channel 2 drives a fixed-length system reset pulse. A shared mask register can silence each action. A masked channel still counts, expires and reports status as usual.

Top module: `tri_wdog`

## Requirements
- R1: After reset, every channel's counter and limit hold 1, every status byte reads 0, the mask reads 0, and irq_o, cpu_rst_o and sys_rst_o are low.
- R2: Channel n occupies the 16-byte window at offset 16·n. Within it, the counter is at 0x0, the limit at 0x4 and the status at 0x8. The mask is at 0x30. Offset 0x34 and every unmapped offset read as zero. Writes to a counter, a status or 0x34 change nothing. Read data appears on bus_rdata in the cycle after the read is sampled.
- R3: The prescaler issues its first tick on clock edge TICK_DIV−1 after reset release, counting edges from 0. It then ticks every TICK_DIV edges. Each tick decrements every running counter by one.
- R4: A limit write stores the value and loads it into the counter. A nonzero value sets running and clears expired. A value of 0 makes the channel expired on that same edge.
- R5: A counter read returns the count held before the edge and reloads the counter from the limit, with the same effect as R4. A limit read or a status read has no side effect.
- R6: When a reload and a tick fall on the same edge, the reload wins, and that tick does not decrement the reloaded counter.
- R7: When a running counter steps from 1 to 0, the channel clears running and sets expired, and the counter stays at 0. Status bit 0 is running, bit 1 is expired, and bits 7:2 read as zero.
- R8: Mask bits 2:0 belong to channels 0 to 2 and are read/write. All other mask bits read as zero. A set bit suppresses only that channel's action output; counting and status carry on.
- R9: irq_o is high for as long as channel 0 is expired and its mask bit is clear. It follows later changes of the mask.
- R10: When channel 1 goes from not expired to expired with its mask bit clear, cpu_rst_o goes high from that edge for RST_PULSE cycles. Clearing the mask after expiry produces no pulse.
- R11: Channel 2 drives sys_rst_o by the same rule as R10, independently of channel 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Bus access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte offset |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Read data, registered |
| irq_o | output | 1 | Channel 0 interrupt, level |
| cpu_rst_o | output | 1 | Channel 1 CPU reset pulse |
| sys_rst_o | output | 1 | Channel 2 system reset pulse |

## Verification
A keep-alive reload and a prescaler tick can fall on the same edge. The bench provokes this by timing a counter read onto a computed tick edge. It judges the result in two ways. The returned count must be the value held before that edge. The next expiry must land a full limit's worth of later ticks after the read, with no tick lost to the collision. A later counter read on an already expired channel tests expiry against reload: it must return zero and drop the interrupt at once.

// File: rtl/tri_wdog.sv
module tri_wdog #(
  parameter int TICK_DIV  = 10_000_000,
  parameter int RST_PULSE = 32,
  parameter int CNT_W     = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_en,
  input  logic             bus_we,
  input  logic [5:0]       bus_addr,
  input  logic [CNT_W-1:0] bus_wdata,
  output logic [CNT_W-1:0] bus_rdata,
  output logic             irq_o,
  output logic             cpu_rst_o,
  output logic             sys_rst_o
);
  localparam int NCH = 3;
  localparam int PW  = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int PCW = $clog2(RST_PULSE + 1);

  logic [PW-1:0] pre;
  logic          tick;
  assign tick = (pre == PW'(TICK_DIV - 1));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pre <= '0;
    else        pre <= tick ? '0 : pre + 1'b1;

  logic [1:0] win;
  logic [3:0] off;
  logic       rd_en, wr_en;
  assign win   = bus_addr[5:4];
  assign off   = bus_addr[3:0];
  assign rd_en = bus_en && !bus_we;
  assign wr_en = bus_en && bus_we;

  logic [CNT_W-1:0] cnt      [NCH];
  logic [CNT_W-1:0] lim      [NCH];
  logic [CNT_W-1:0] load_val [NCH];
  logic [NCH-1:0]   run, expd, mask, load, lim_wr, expire_now;

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      lim_wr[i]     = wr_en && (win == 2'(i)) && (off == 4'h4);
      load[i]       = lim_wr[i] || (rd_en && (win == 2'(i)) && (off == 4'h0));
      load_val[i]   = lim_wr[i] ? bus_wdata : lim[i];
      expire_now[i] = load[i] ? (load_val[i] == '0)
                              : (tick && run[i] && (cnt[i] == CNT_W'(1)));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) begin
        cnt[i] <= CNT_W'(1);
        lim[i] <= CNT_W'(1);
      end
      run  <= '0;
      expd <= '0;
    end else begin
      for (int i = 0; i < NCH; i++) begin
        if (load[i]) begin
          cnt[i]  <= load_val[i];
          run[i]  <= (load_val[i] != '0);
          expd[i] <= (load_val[i] == '0);
          if (lim_wr[i]) lim[i] <= bus_wdata;
        end else if (tick && run[i]) begin
          cnt[i] <= cnt[i] - 1'b1;
          if (cnt[i] == CNT_W'(1)) begin
            run[i]  <= 1'b0;
            expd[i] <= 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                                 mask <= '0;
    else if (wr_en && win == 2'd3 && off == 4'h0) mask <= bus_wdata[NCH-1:0];

  logic [PCW-1:0] pc_cpu, pc_sys;
  logic           fire_cpu, fire_sys;
  assign fire_cpu = expire_now[1] && !expd[1] && !mask[1];
  assign fire_sys = expire_now[2] && !expd[2] && !mask[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_cpu <= '0;
      pc_sys <= '0;
    end else begin
      if (fire_cpu)            pc_cpu <= PCW'(RST_PULSE);
      else if (pc_cpu != '0)   pc_cpu <= pc_cpu - 1'b1;
      if (fire_sys)            pc_sys <= PCW'(RST_PULSE);
      else if (pc_sys != '0)   pc_sys <= pc_sys - 1'b1;
    end
  end

  assign cpu_rst_o = (pc_cpu != '0);
  assign sys_rst_o = (pc_sys != '0);
  assign irq_o     = expd[0] && !mask[0];

  logic [CNT_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (win == 2'd3) begin
      if (off == 4'h0) rd_mux = CNT_W'(mask);
    end else begin
      for (int i = 0; i < NCH; i++) begin
        if (win == 2'(i)) begin
          case (off)
            4'h0:    rd_mux = cnt[i];
            4'h4:    rd_mux = lim[i];
            4'h8:    rd_mux = CNT_W'({expd[i], run[i]});
            default: rd_mux = '0;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     bus_rdata <= '0;
    else if (rd_en) bus_rdata <= rd_mux;

  logic armed;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;

  for (genvar g = 0; g < NCH; g++) begin : g_chk
    // R7
    hold_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      expd[g] |-> cnt[g] == '0);
    // R7
    run_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(run[g] && expd[g]));
    // R4
    lim_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      armed && $past(lim_wr[g]) |-> cnt[g] == $past(bus_wdata) && lim[g] == $past(bus_wdata));
    // R3
    step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      armed && $past(run[g]) && !$past(load[g]) |->
        (cnt[g] == $past(cnt[g]) || cnt[g] == $past(cnt[g]) - 1'b1));
  end

  // R9
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(expd[0]) && !$past(load[0]) && !mask[0] |-> irq_o);
  // R10
  cpu_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $rose(cpu_rst_o) |-> expd[1] && !$past(expd[1]) && !$past(mask[1]));
  // R11
  sys_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $rose(sys_rst_o) |-> expd[2] && !$past(expd[2]) && !$past(mask[2]));
endmodule

// File: tb/tb_tri_wdog.sv
`timescale 1ns/1ps
module tb_tri_wdog;
  localparam int D = 8;
  localparam int P = 5;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_en, bus_we;
  logic [5:0]  bus_addr;
  logic [15:0] bus_wdata, bus_rdata;
  logic        irq_o, cpu_rst_o, sys_rst_o;

  always #2 clk = ~clk;

  tri_wdog #(.TICK_DIV(D), .RST_PULSE(P), .CNT_W(16)) dut (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .cpu_rst_o(cpu_rst_o), .sys_rst_o(sys_rst_o));

  int cyc = 0;
  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  int n_chk = 0, n_bad = 0;

  typedef struct { logic [15:0] v; string tag; } exp_t;
  exp_t q[$];
  exp_t mon_e;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  always @(posedge clk) begin
    if (rst_n && bus_en && !bus_we) begin
      #1;
      if (q.size() == 0) chk(1'b0, "R2 unexpected read", 0, 0);
      else begin
        mon_e = q.pop_front();
        chk(bus_rdata == mon_e.v, mon_e.tag, bus_rdata, mon_e.v);
      end
    end
  end

  task automatic rd(input logic [5:0] a, input logic [15:0] ev, input string tag, output int e);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    q.push_back('{ev, tag});
    e = cyc;
    @(negedge clk);
    bus_en = 1'b0;
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d, output int e);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    e = cyc;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic goto(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  function automatic bit is_tick(input int t);
    return (t % D) == D - 1;
  endfunction

  function automatic int ticks_in(input int a, input int b);
    int n = 0;
    for (int t = a + 1; t < b; t++) if (is_tick(t)) n++;
    return n;
  endfunction

  function automatic int exp_edge(input int w, input int l);
    int t = w, n = 0;
    while (n < l) begin
      t++;
      if (is_tick(t)) n++;
    end
    return t;
  endfunction

  initial begin
    #(4 * 150000);
    chk(1'b0, "watchdog timeout", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    int w, r, x, e, e2, tk;
    rst_n = 1'b0; bus_en = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk(irq_o == 0 && cpu_rst_o == 0 && sys_rst_o == 0, "R1 outputs low", {irq_o, cpu_rst_o, sys_rst_o}, 0);
    rd(6'h04, 16'd1, "R1 ch0 limit", x);
    rd(6'h14, 16'd1, "R1 ch1 limit", x);
    rd(6'h24, 16'd1, "R1 ch2 limit", x);
    rd(6'h08, 16'd0, "R1 ch0 status", x);
    rd(6'h30, 16'd0, "R1 mask", x);
    rd(6'h34, 16'd0, "R2 opaque byte", x);
    rd(6'h3C, 16'd0, "R2 unmapped", x);

    rd(6'h00, 16'd1, "R1 R5 ch0 counter", r);
    e = exp_edge(r, 1);
    goto(e);   chk(irq_o == 0, "R3 no early irq", irq_o, 0);
    goto(e + 1); chk(irq_o == 1, "R3 R9 irq at expiry", irq_o, 1);

    wr(6'h30, 16'h1, w);
    chk(irq_o == 0, "R8 R9 masked irq", irq_o, 0);
    rd(6'h08, 16'h2, "R8 status while masked", x);
    wr(6'h30, 16'h0, w);
    chk(irq_o == 1, "R9 irq after unmask", irq_o, 1);

    wr(6'h04, 16'd3, w);
    chk(irq_o == 0, "R4 limit write clears expiry", irq_o, 0);
    tk = cyc;
    while (!is_tick(tk)) tk++;
    goto(tk);
    rd(6'h00, 16'(3 - ticks_in(w, tk)), "R5 R6 counter read on tick", r);
    e2 = exp_edge(r, 3);
    rd(6'h04, 16'd3, "R5 limit read", x);
    rd(6'h08, 16'h1, "R7 running status", x);
    goto(e2);    chk(irq_o == 0, "R6 reload beat tick", irq_o, 0);
    goto(e2 + 1); chk(irq_o == 1, "R3 R6 expiry edge", irq_o, 1);
    rd(6'h08, 16'h2, "R7 expired status", x);
    rd(6'h00, 16'd0, "R7 held at zero", r);
    chk(irq_o == 0, "R5 read reload clears expiry", irq_o, 0);

    wr(6'h04, 16'd0, w);
    chk(irq_o == 1, "R4 zero limit expires at once", irq_o, 1);
    rd(6'h08, 16'h2, "R4 R7 zero limit status", x);

    wr(6'h30, 16'h2, w);
    wr(6'h14, 16'd2, w);
    e = exp_edge(w, 2);
    goto(e + 1); chk(cpu_rst_o == 0, "R8 masked ch1 no reset", cpu_rst_o, 0);
    rd(6'h18, 16'h2, "R8 R7 masked ch1 still expires", x);
    goto(e + P + 2); chk(cpu_rst_o == 0, "R8 masked ch1 quiet", cpu_rst_o, 0);
    wr(6'h30, 16'h0, w);
    goto(w + 3); chk(cpu_rst_o == 0, "R10 no pulse on late unmask", cpu_rst_o, 0);

    wr(6'h14, 16'd1, w);
    e = exp_edge(w, 1);
    goto(e);     chk(cpu_rst_o == 0, "R10 no early pulse", cpu_rst_o, 0);
    goto(e + 1); chk(cpu_rst_o == 1, "R10 pulse start", cpu_rst_o, 1);
    chk(sys_rst_o == 0, "R11 channels independent", sys_rst_o, 0);
    goto(e + P);     chk(cpu_rst_o == 1, "R10 pulse last cycle", cpu_rst_o, 1);
    goto(e + P + 1); chk(cpu_rst_o == 0, "R10 pulse end", cpu_rst_o, 0);

    wr(6'h24, 16'd2, w);
    e = exp_edge(w, 2);
    goto(e);     chk(sys_rst_o == 0, "R11 no early pulse", sys_rst_o, 0);
    goto(e + 1); chk(sys_rst_o == 1, "R11 pulse start", sys_rst_o, 1);
    chk(cpu_rst_o == 0, "R10 quiet during ch2", cpu_rst_o, 0);
    goto(e + P);     chk(sys_rst_o == 1, "R11 pulse last cycle", sys_rst_o, 1);
    goto(e + P + 1); chk(sys_rst_o == 0, "R11 pulse end", sys_rst_o, 0);

    wr(6'h20, 16'h0055, w);
    wr(6'h28, 16'h00FF, w);
    wr(6'h34, 16'h00FF, w);
    rd(6'h24, 16'd2, "R2 limit after ignored writes", x);
    rd(6'h28, 16'h2, "R2 R7 status after ignored writes", x);
    rd(6'h34, 16'd0, "R2 opaque after write", x);
    chk(sys_rst_o == 0, "R2 ignored writes no action", sys_rst_o, 0);

    wr(6'h30, 16'hFFFF, w);
    rd(6'h30, 16'h0007, "R8 mask width", x);
    chk(irq_o == 0, "R9 irq follows mask", irq_o, 0);

    while (q.size() != 0) @(negedge clk);
    @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule